// File: doc/BRIEF.md
# ADC Serial Command Power-Down Controller

This block is the serial-port mode controller of a multichannel sampling converter. A host frames each transfer with an active-low chip select. During the frame it clocks a 16-bit command word into the block, MSB first. In the same frame it reads back a 16-bit response. The block decodes each command as one of five kinds: a conversion request (auto-scan restart or a fixed-channel selection), the power-down request, a program-register write, a program-register read, or nothing. Mode changes and register writes take effect only when chip select rises at the end of a frame that carried at least 16 clocks.

The controller keeps one of three modes: powered down, settling, or ready. A conversion request wakes it from power-down. It then waits a parameterised number of system-clock cycles, the settling window, before the data-valid flag goes high. No window is applied when the program registers select an external reference. An active-low hardware power-down pin can also force the powered-down mode. That path reloads the register defaults, while the software path keeps them. A stub outside the block supplies the conversion samples.

All serial pins are oversampled in the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `adc_pd_ctrl`

## Requirements
- R1: After reset the block is powered down: data_valid is 0, sdo is 0, chan_sel is 0, scan_mode is 0, and every program register holds REG_DEFAULT.
- R2: SDI is sampled on the SCLK rising edges. The first 16 bits of a frame form the word, MSB first. A frame that ends with fewer than 16 SCLK rising edges changes nothing. The bit counter clears while cs_n is high.
- R3: The word 8300h puts the block into power-down. The change happens at the cs_n rising edge of that frame and not earlier, even while cs_n stays low after the 16th bit.
- R4: While powered down, the block stays powered down after a frame with SDI held low, after an unrecognised word (for example 8500h), and after any register access.
- R5: Power-down is left at the cs_n rising edge of a frame carrying one of two words. The word A000h selects channel 0 with scan_mode = 1. The word C000h + n·0400h, with n < NUM_CH, selects channel n with scan_mode = 0. The same pattern with n ≥ NUM_CH is ignored.
- R6: On wake-up with bit 0 of register 1 at 0 (internal reference), data_valid stays 0 for SETTLE_CYCLES clock cycles and then rises. With that bit at 1, data_valid rises right after the waking frame.
- R7: A word with bit 15 = 0 and bit 8 = 1 writes bits 7:0 into the register addressed by bits 14:9 (valid addresses 1 to NUM_REGS). The write is applied at the cs_n rising edge, in every mode.
- R8: A word with bit 15 = 0 and bit 8 = 0, other than 0000h, reads the addressed register. SDO bits 17 to 24 of the same frame return the register value, and bits 25 to 32 return zero. The read also works while powered down.
- R9: While settling or ready, in a frame that is not a register read, SDO bits 17 to 32 carry the conv_data value captured when cs_n fell, MSB first. SDO changes on SCLK falling edges.
- R10: In a 32-clock frame that starts while powered down and is not a register read, SDO bits 17 to 32 carry the FILLER pattern.
- R11: While hw_pd_n is low, the block is powered down, data_valid is 0, frames are ignored and the registers hold their defaults. After release it stays powered down with default registers.
- R12: Software power-down and the wake-up that follows keep the program register values.
- R13: A conversion command while settling or ready updates chan_sel and scan_mode. It neither leaves the mode nor restarts the settling window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_pd_n | input | 1 | Hardware power-down, active low, asynchronous |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial command data in |
| sdo | output | 1 | Serial response data out |
| conv_data | input | 16 | Conversion sample from the converter stub |
| powered_down | output | 1 | High while in power-down mode |
| data_valid | output | 1 | High when conversion data is settled and valid |
| chan_sel | output | 3 | Selected input channel |
| scan_mode | output | 1 | High when auto-scan is selected |

## Verification
The embedded properties watch the mode machine on every cycle. They check that power-down is held until a committed conversion command arrives, that the end of the settling count moves the block to ready, and that the hardware pin forces power-down. They also watch the settling counter's step-by-step descent, the frame bit counter's bound and clearing, and that the register bank is stable unless a write or the hardware reload acts on it. The exact serial encodings can only be shown by the bench's frame scenarios: which words wake the block, what SDO returns in each mode, and that out-of-range channels and short frames are ignored. The same holds for the length of the settling window and for register retention across software power-down compared with the hardware reload.

// File: rtl/adc_pd_pkg.sv
// Package: shared types and command decode for the serial power-down controller.
// Assumes 16-bit command words; channel field is 3 bits, address field 6 bits.
package adc_pd_pkg;

    typedef enum logic [1:0] {
        ST_PD     = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2
    } mode_t;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_PWRDN = 3'd1,
        K_AUTO  = 3'd2,
        K_MAN   = 3'd3,
        K_WR    = 3'd4,
        K_RD    = 3'd5
    } kind_t;

    typedef struct packed {
        kind_t       kind;
        logic [2:0]  chan;
        logic [5:0]  addr;
        logic [7:0]  data;
    } cmd_t;

    localparam logic [15:0] WORD_PWRDN = 16'h8300;
    localparam logic [15:0] WORD_AUTO  = 16'hA000;

    // Classify one 16-bit word against channel and register counts.
    function automatic cmd_t decode_word(input logic [15:0] w,
                                         input int unsigned num_ch,
                                         input int unsigned num_regs);
        cmd_t r;
        r.kind = K_NONE;
        r.chan = w[12:10];
        r.addr = w[14:9];
        r.data = w[7:0];
        if (w == WORD_PWRDN) begin
            r.kind = K_PWRDN;
        end else if (w == WORD_AUTO) begin
            r.kind = K_AUTO;
            r.chan = 3'd0;
        end else if (w[15:13] == 3'b110 && w[9:0] == 10'd0 &&
                     32'(w[12:10]) < num_ch) begin
            r.kind = K_MAN;
        end else if (!w[15] && w != 16'd0 && w[14:9] != 6'd0 &&
                     32'(w[14:9]) <= num_regs) begin
            r.kind = w[8] ? K_WR : K_RD;
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_frame_shifter.sv
// Frame shifter: oversamples cs_n/sclk/sdi in the clk domain, assembles the
// command word, flags frame boundaries and serialises the response on SDO.
// Assumes sclk half period of at least three clk cycles.
module adc_frame_shifter #(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned FRAME_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic [WORD_W-1:0] payload_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_ok_o,
    output logic              frame_start_o,
    output logic              frame_end_o,
    output logic              sdo_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
    localparam int unsigned NSYNC = 3;

    logic [NSYNC-1:0]  sync_q [2];
    logic              cs_s, sclk_s, sdi_s;
    logic              cs_prev_q, sclk_prev_q, sdi_q;
    logic              s_rise, s_fall, cs_rise, cs_fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shift_q, word_q, sdo_sr_q;
    logic              word_ok_q, sdo_q;

    // Two-stage synchronisers for chip select and serial clock.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= {NSYNC{1'b1}};
            else        sync_q[g] <= {sync_q[g][NSYNC-2:0], (g == 0) ? cs_n_i : sclk_i};
        end
    end

    assign cs_s   = sync_q[0][1];
    assign sclk_s = sync_q[1][1];

    // Data pin synchroniser matched to the clock path delay.
    logic sdi_m_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdi_m_q <= 1'b0;
            sdi_q   <= 1'b0;
        end else begin
            sdi_m_q <= sdi_i;
            sdi_q   <= sdi_m_q;
        end
    end
    assign sdi_s = sdi_q;

    // Previous values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            cs_prev_q   <= cs_s;
            sclk_prev_q <= sclk_s;
        end
    end

    assign s_rise  = sclk_s & ~sclk_prev_q & ~cs_s;
    assign s_fall  = ~sclk_s & sclk_prev_q & ~cs_s;
    assign cs_rise = cs_s & ~cs_prev_q;
    assign cs_fall = ~cs_s & cs_prev_q;

    // Bit counter: clears while deselected, saturates at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt_q <= '0;
        else if (cs_s)                            cnt_q <= '0;
        else if (s_rise && cnt_q < CNT_W'(FRAME_BITS)) cnt_q <= cnt_q + 1'b1;
    end

    // Command capture: shift the first WORD_W bits, latch the full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            word_q    <= '0;
            word_ok_q <= 1'b0;
        end else begin
            if (cs_fall) word_ok_q <= 1'b0;
            if (s_rise && cnt_q < CNT_W'(WORD_W - 1)) begin
                shift_q <= {shift_q[WORD_W-2:0], sdi_s};
            end else if (s_rise && cnt_q == CNT_W'(WORD_W - 1)) begin
                word_q    <= {shift_q[WORD_W-2:0], sdi_s};
                word_ok_q <= 1'b1;
            end
        end
    end

    // Response serialiser: load at the WORD_W-th falling edge, shift after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q    <= 1'b0;
            sdo_sr_q <= '0;
        end else if (cs_s) begin
            sdo_q <= 1'b0;
        end else if (s_fall && cnt_q == CNT_W'(WORD_W)) begin
            sdo_q    <= payload_i[WORD_W-1];
            sdo_sr_q <= {payload_i[WORD_W-2:0], 1'b0};
        end else if (s_fall && cnt_q > CNT_W'(WORD_W) && cnt_q < CNT_W'(FRAME_BITS)) begin
            sdo_q    <= sdo_sr_q[WORD_W-1];
            sdo_sr_q <= {sdo_sr_q[WORD_W-2:0], 1'b0};
        end
    end

    assign word_o        = word_q;
    assign word_ok_o     = word_ok_q;
    assign frame_start_o = cs_fall;
    assign frame_end_o   = cs_rise;
    assign sdo_o         = sdo_q;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_BITS));
    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> cnt_q == '0);
    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_rise && cnt_q == CNT_W'(WORD_W - 1)) |=> $stable(word_q));

endmodule

// File: rtl/adc_prog_regs.sv
// Program register bank: NUM_REGS byte registers at addresses 1..NUM_REGS.
// Assumes writes arrive as single-cycle strobes; clear_i reloads defaults.
module adc_prog_regs #(
    parameter int unsigned NUM_REGS    = 4,
    parameter logic [7:0]  REG_DEFAULT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       we_i,
    input  logic [5:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       ext_ref_o
);
    localparam int unsigned FLAT_W = NUM_REGS * 8;

    logic [7:0]        regs_q [NUM_REGS];
    logic [FLAT_W-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // One register: defaults on reset or hardware clear, else addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs_q[g] <= REG_DEFAULT;
            else if (clear_i)                            regs_q[g] <= REG_DEFAULT;
            else if (we_i && addr_i == 6'(g + 1))        regs_q[g] <= wdata_i;
        end
        assign flat[g*8 +: 8] = regs_q[g];
    end

    // Read mux; unmatched addresses return zero.
    always_comb begin
        rdata_o = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (addr_i == 6'(k + 1)) rdata_o = regs_q[k];
        end
    end

    assign ext_ref_o = regs_q[0][0];

    p_clear_default_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> regs_q[0] == REG_DEFAULT);
    p_keep_values_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !clear_i) |=> $stable(flat));

endmodule

// File: rtl/adc_settle_timer.sv
// Settling timer: counts CYCLES clk cycles after start_i, pulses done_o.
// Assumes CYCLES >= 1; abort_i cancels a running count.
module adc_settle_timer #(
    parameter int unsigned CYCLES = 1875000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic done_o
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Down-counter with run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (abort_i) begin
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = run_q && cnt_q == '0 && !abort_i;

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !abort_i && !start_i && cnt_q != '0) |=>
        (run_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_mode_fsm.sv
// Mode machine: powered-down / settling / ready, plus channel and scan state.
// Assumes commit_i is a one-cycle pulse at the end of a complete frame.
module adc_mode_fsm
    import adc_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_pd_i,
    input  logic       commit_i,
    input  cmd_t       cmd_i,
    input  logic       ext_ref_i,
    input  logic       settle_done_i,
    output mode_t      mode_o,
    output logic [2:0] chan_o,
    output logic       scan_o,
    output logic       start_o,
    output logic       abort_o
);
    mode_t      mode_q, mode_d;
    logic [2:0] chan_q, chan_d;
    logic       scan_q, scan_d;
    logic       is_conv;

    assign is_conv = (cmd_i.kind == K_AUTO) || (cmd_i.kind == K_MAN);
    assign start_o = commit_i && is_conv && mode_q == ST_PD && !ext_ref_i && !hw_pd_i;
    assign abort_o = hw_pd_i || (commit_i && cmd_i.kind == K_PWRDN);

    // Next-state decision.
    always_comb begin
        mode_d = mode_q;
        chan_d = chan_q;
        scan_d = scan_q;
        if (hw_pd_i) begin
            mode_d = ST_PD;
            chan_d = 3'd0;
            scan_d = 1'b0;
        end else if (commit_i && cmd_i.kind == K_PWRDN) begin
            mode_d = ST_PD;
        end else if (commit_i && is_conv) begin
            chan_d = cmd_i.chan;
            scan_d = (cmd_i.kind == K_AUTO);
            case (mode_q)
                ST_PD:     mode_d = ext_ref_i ? ST_READY : ST_SETTLE;
                ST_SETTLE: mode_d = settle_done_i ? ST_READY : ST_SETTLE;
                default:   mode_d = ST_READY;
            endcase
        end else if (mode_q == ST_SETTLE && settle_done_i) begin
            mode_d = ST_READY;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ST_PD;
            chan_q <= 3'd0;
            scan_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            chan_q <= chan_d;
            scan_q <= scan_d;
        end
    end

    assign mode_o = mode_q;
    assign chan_o = chan_q;
    assign scan_o = scan_q;

    p_hw_forces_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_pd_i |=> (mode_q == ST_PD && chan_q == 3'd0));
    p_stay_pd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_PD && !(commit_i && is_conv)) |=> mode_q == ST_PD);
    p_settle_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_SETTLE && settle_done_i && !abort_o) |=> mode_q == ST_READY);

endmodule

// File: rtl/adc_pd_ctrl.sv
// Top: serial command power-down controller. Ties the frame shifter, decode,
// mode machine, settling timer and program registers together.
// Assumes sclk is much slower than clk; hw_pd_n may change at any time.
module adc_pd_ctrl
    import adc_pd_pkg::*;
#(
    parameter int unsigned NUM_CH        = 4,
    parameter int unsigned NUM_REGS      = 4,
    parameter int unsigned SETTLE_CYCLES = 1875000,
    parameter logic [7:0]  REG_DEFAULT   = 8'h00,
    parameter logic [15:0] FILLER        = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_pd_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    input  logic [15:0] conv_data,
    output logic        powered_down,
    output logic        data_valid,
    output logic [2:0]  chan_sel,
    output logic        scan_mode
);
    localparam int unsigned WORD_W = 16;

    logic [1:0]        hwpd_sync_q;
    logic              hw_pd;
    logic [WORD_W-1:0] word, payload, conv_q;
    logic              word_ok, frame_start, frame_end, commit;
    cmd_t              cmd;
    mode_t             mode;
    logic [7:0]        rdata;
    logic              ext_ref, settle_done, start, abort;

    // Hardware power-down pin synchroniser (1 = not asserted).
    always_ff @(posedge clk) begin
        if (!rst_n) hwpd_sync_q <= 2'b11;
        else        hwpd_sync_q <= {hwpd_sync_q[0], hw_pd_n};
    end
    assign hw_pd = ~hwpd_sync_q[1];

    adc_frame_shifter #(.WORD_W(WORD_W), .FRAME_BITS(2 * WORD_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .payload_i(payload), .word_o(word), .word_ok_o(word_ok),
        .frame_start_o(frame_start), .frame_end_o(frame_end), .sdo_o(sdo)
    );

    assign cmd    = decode_word(word, NUM_CH, NUM_REGS);
    assign commit = frame_end && word_ok && !hw_pd;

    // Sample capture at the start of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           conv_q <= '0;
        else if (frame_start) conv_q <= conv_data;
    end

    // Response selection: readback, filler in power-down, else sample.
    always_comb begin
        if (cmd.kind == K_RD)  payload = {rdata, 8'h00};
        else if (mode == ST_PD) payload = FILLER;
        else                    payload = conv_q;
    end

    adc_prog_regs #(.NUM_REGS(NUM_REGS), .REG_DEFAULT(REG_DEFAULT)) regs_i (
        .clk(clk), .rst_n(rst_n), .clear_i(hw_pd),
        .we_i(commit && cmd.kind == K_WR), .addr_i(cmd.addr),
        .wdata_i(cmd.data), .rdata_o(rdata), .ext_ref_o(ext_ref)
    );

    adc_settle_timer #(.CYCLES(SETTLE_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .done_o(settle_done)
    );

    adc_mode_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .hw_pd_i(hw_pd), .commit_i(commit),
        .cmd_i(cmd), .ext_ref_i(ext_ref), .settle_done_i(settle_done),
        .mode_o(mode), .chan_o(chan_sel), .scan_o(scan_mode),
        .start_o(start), .abort_o(abort)
    );

    assign powered_down = (mode == ST_PD);
    assign data_valid   = (mode == ST_READY);

    p_pd_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hw_pd) |-> !data_valid);

endmodule

// File: tb/adc_pd_ctrl_tb_top.sv
module adc_pd_ctrl_tb_top;
    localparam int SETTLE = 300;
    localparam int HALF   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_pd_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [15:0] conv_data = 16'h0000;
    logic        powered_down, data_valid, scan_mode;
    logic [2:0]  chan_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_pd_ctrl #(.NUM_CH(4), .NUM_REGS(4), .SETTLE_CYCLES(SETTLE),
                  .REG_DEFAULT(8'h00), .FILLER(16'hFFFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_pd_n(hw_pd_n), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .conv_data(conv_data), .powered_down(powered_down),
        .data_valid(data_valid), .chan_sel(chan_sel), .scan_mode(scan_mode)
    );

    // Row: {cmd, conv, exp_sdo, exp_pd, exp_valid, exp_ch, exp_scan}
    localparam int NV = 13;
    localparam logic [53:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 3'd0, 1'b0}, // R4 R10
        {16'h035A, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 3'd0, 1'b0}, // R7
        {16'h0200, 16'h0000, 16'h5A00, 1'b1, 1'b0, 3'd0, 1'b0}, // R8
        {16'h053C, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 3'd0, 1'b0}, // R7
        {16'hD400, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 3'd0, 1'b0}, // R5 channel 5 out of range
        {16'h8500, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 3'd0, 1'b0}, // R4 unknown word
        {16'hC800, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 3'd2, 1'b0}, // R5 wake on channel 2
        {16'h0000, 16'h1234, 16'h1234, 1'b0, 1'b1, 3'd2, 1'b0}, // R9
        {16'hA000, 16'hABCD, 16'hABCD, 1'b0, 1'b1, 3'd0, 1'b1}, // R9 R13
        {16'h0400, 16'h0000, 16'h3C00, 1'b0, 1'b1, 3'd0, 1'b1}, // R8
        {16'h8300, 16'h5555, 16'h5555, 1'b1, 1'b0, 3'd0, 1'b1}, // R3
        {16'h0200, 16'h0000, 16'h5A00, 1'b1, 1'b0, 3'd0, 1'b1}, // R12
        {16'h0000, 16'h7777, 16'hFFFF, 1'b1, 1'b0, 3'd0, 1'b1}  // R10
    };

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One frame: nclk serial clocks, optional CS release; returns SDO bits 17..32.
    task automatic frame(input logic [15:0] w, input int nclk, input bit raise,
                         output logic [15:0] rd);
        rd = '0;
        wclk(4);
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = 1; i <= nclk; i++) begin
            sdi = (i <= 16) ? w[16 - i] : 1'b0;
            wclk(HALF);
            if (i >= 17) rd[32 - i] = sdo;
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
        wclk(HALF);
        sdi = 1'b0;
        if (raise) cs_n = 1'b1;
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        // R1 reset state
        chk("R1 pd", 16'(powered_down), 16'd1);
        chk("R1 valid", 16'(data_valid), 16'd0);
        chk("R1 sdo", 16'(sdo), 16'd0);
        chk("R1 chan", 16'(chan_sel), 16'd0);
        chk("R1 scan", 16'(scan_mode), 16'd0);
        frame(16'h0200, 32, 1'b1, rd);
        chk("R1 reg default", rd, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            conv_data = VEC[v][37:22];
            frame(VEC[v][53:38], 32, 1'b1, rd);
            chk($sformatf("R9/R10/R8 vec%0d sdo", v), rd, VEC[v][21:6]);
            wclk(2 * SETTLE);
            chk($sformatf("R3/R4/R5 vec%0d pd", v), 16'(powered_down), 16'(VEC[v][5]));
            chk($sformatf("R6 vec%0d valid", v), 16'(data_valid), 16'(VEC[v][4]));
            chk($sformatf("R5/R13 vec%0d chan", v), 16'(chan_sel), 16'(VEC[v][3:1]));
            chk($sformatf("R5/R13 vec%0d scan", v), 16'(scan_mode), 16'(VEC[v][0]));
        end

        // R2 short frame is ignored
        frame(16'hC000, 10, 1'b1, rd);
        wclk(20);
        chk("R2 short frame pd", 16'(powered_down), 16'd1);

        // R6 internal reference settling window
        frame(16'hC400, 32, 1'b1, rd);
        wclk(SETTLE / 2);
        chk("R6 left pd", 16'(powered_down), 16'd0);
        chk("R6 valid low while settling", 16'(data_valid), 16'd0);
        wclk(SETTLE / 2 + 40);
        chk("R6 valid after window", 16'(data_valid), 16'd1);
        chk("R6 chan", 16'(chan_sel), 16'd1);

        // R13 conversion command while ready keeps valid
        frame(16'hA000, 32, 1'b1, rd);
        wclk(20);
        chk("R13 valid kept", 16'(data_valid), 16'd1);
        chk("R13 scan", 16'(scan_mode), 16'd1);

        // R3 power-down waits for CS rising edge
        frame(16'h8300, 16, 1'b0, rd);
        wclk(20);
        chk("R3 before cs rise", 16'(powered_down), 16'd0);
        cs_n = 1'b1;
        wclk(20);
        chk("R3 after cs rise", 16'(powered_down), 16'd1);

        // R6 external reference: no settling
        frame(16'h0301, 32, 1'b1, rd);
        frame(16'hC000, 32, 1'b1, rd);
        wclk(20);
        chk("R6 ext ref valid", 16'(data_valid), 16'd1);

        // R11 hardware power-down
        hw_pd_n = 1'b0;
        wclk(10);
        chk("R11 pd", 16'(powered_down), 16'd1);
        chk("R11 valid", 16'(data_valid), 16'd0);
        frame(16'hC000, 32, 1'b1, rd);
        wclk(20);
        chk("R11 frame ignored", 16'(powered_down), 16'd1);
        hw_pd_n = 1'b1;
        wclk(10);
        chk("R11 stays pd", 16'(powered_down), 16'd1);
        frame(16'h0400, 32, 1'b1, rd);
        chk("R11 reg2 default", rd, 16'h0000);
        frame(16'h0200, 32, 1'b1, rd);
        chk("R11 reg1 default", rd, 16'h0000);
        chk("R11 chan", 16'(chan_sel), 16'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule